// File: doc/BRIEF.md
# Conditional Incrementer by Lowest-Zero Search

This block adds a single carry bit to a k-bit value without a carry chain. A divide-and-conquer tree finds the least-significant zero in the value and produces a thermometer mask that covers bit 0 up to and including that zero. When the carry is set, the bits under the mask are inverted and the bits above it are passed through. When the carry is clear, the value comes out unchanged. The stage is meant to sit at each level of a split adder. There, the upper half-sum is computed with no carry-in and is fixed up later by this stage once the lower half's carry-out is known.

The width is a parameter and must be a power of two from 2 to 32, so one description serves every level of the adder tree. The tree splits the value into halves until it reaches 2-bit leaves. Each node merges its two children: it passes the upper child's mask only when the lower child is all ones, and it ANDs the two all-ones flags. One output register stage holds the result, an all-ones flag and a position mask. The flag doubles as the overflow indication when the carry is set. The mask is a thermometer by default and can be set to a one-hot form that marks only the lowest zero.

Top module: `lzinc_stage`

## Requirements
- R1: A rising clock edge with rst_n low forces sum_out, all_ones_out and mask_out to all zeros.
- R2: Outputs are registered: they take the value computed from x_in and carry_in sampled at the previous rising edge and do not change between edges.
- R3: With carry_in = 0, sum_out equals x_in.
- R4: With carry_in = 1, sum_out equals x_in + 1 modulo 2^WIDTH. Bits 0 up to and including the lowest zero of x_in are inverted, and the higher bits are unchanged.
- R5: With x_in all ones and carry_in = 1, sum_out is zero and all_ones_out is 1 (overflow).
- R6: all_ones_out is 1 exactly when every bit of x_in is 1, whatever carry_in is.
- R7: With MASK_ONEHOT = 0, mask_out bit i is 1 exactly when bits 0 to i-1 of x_in are all 1. This covers bits 0 through the lowest zero, and all bits when x_in is all ones. The mask does not depend on carry_in.
- R8: With MASK_ONEHOT = 1, mask_out has only the bit at the position of the lowest zero of x_in set, and is zero when x_in is all ones. The mask does not depend on carry_in.
- R9: R3 to R8 hold for every power-of-two WIDTH from 2 to 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| x_in | input | WIDTH | Value to be conditionally incremented |
| carry_in | input | 1 | Carry bit to add to x_in |
| sum_out | output | WIDTH | Registered x_in + carry_in, truncated |
| all_ones_out | output | 1 | Registered flag: x_in was all ones |
| mask_out | output | WIDTH | Registered lowest-zero mask, thermometer or one-hot |

## Verification
The assertions assume that WIDTH is a power of two in the legal range. They also assume that x_in and carry_in carry known values at every rising edge once reset has been released, and that reset is applied before the first checked edge. The bench holds rst_n low from time zero. It changes inputs only on falling edges and always drives fully defined values. Every 2-bit and 8-bit input and carry combination is driven, along with random values weighted toward long runs of low ones at 16 and 32 bits. This covers the all-ones wrap case and the case where the lowest zero is the top bit.

// File: rtl/lzinc_pkg.sv
// Package lzinc_pkg
// Holds the width limits that the incrementer tree is built against.
// Assumes: widths are powers of two, so every split gives equal halves.
package lzinc_pkg;
    localparam int MIN_WIDTH = 2;
    localparam int MAX_WIDTH = 32;

    // True when a width can be built by halving down to 2-bit leaves.
    function automatic bit width_ok(int w);
        return (w >= MIN_WIDTH) && (w <= MAX_WIDTH) && ((w & (w - 1)) == 0);
    endfunction
endpackage

// File: rtl/lzd_leaf.sv
// Module lzd_leaf
// 2-bit lowest-zero detector. The mask marks bit 0 always and bit 1 only
// when bit 0 is one. The flag reports that both bits are one.
// Assumes: nothing beyond a 2-bit input.
module lzd_leaf (
    input  logic [1:0] bits_in,
    output logic [1:0] therm_out,
    output logic       all_ones_out
);
    // Leaf mask and flag from the two input bits.
    always_comb begin
        therm_out    = {bits_in[0], 1'b1};
        all_ones_out = bits_in[1] & bits_in[0];
    end
endmodule

// File: rtl/lzd_node.sv
// Module lzd_node
// Recursive lowest-zero detector of width W. The value is split into halves.
// The upper half's mask is kept only if the lower half is all ones. The
// all-ones flag is the AND of both halves' flags. Recursion stops at 2-bit
// leaves.
// Assumes: W is a power of two, at least 2.
module lzd_node #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits_in,
    output logic [W-1:0] therm_out,
    output logic         all_ones_out
);
    generate
        if (W == 2) begin : g_leaf
            lzd_leaf u_leaf (
                .bits_in      (bits_in),
                .therm_out    (therm_out),
                .all_ones_out (all_ones_out)
            );
        end else begin : g_split
            localparam int HALF = W / 2;
            logic [HALF-1:0] lo_therm;
            logic [HALF-1:0] hi_therm;
            logic            lo_all;
            logic            hi_all;

            lzd_node #(.W(HALF)) u_lo (
                .bits_in      (bits_in[HALF-1:0]),
                .therm_out    (lo_therm),
                .all_ones_out (lo_all)
            );
            lzd_node #(.W(HALF)) u_hi (
                .bits_in      (bits_in[W-1:HALF]),
                .therm_out    (hi_therm),
                .all_ones_out (hi_all)
            );

            // Stitch: the upper mask survives only past an all-ones lower half.
            always_comb begin
                therm_out    = {hi_therm & {HALF{lo_all}}, lo_therm};
                all_ones_out = lo_all & hi_all;
            end
        end
    endgenerate
endmodule

// File: rtl/lzinc_apply.sv
// Module lzinc_apply
// Applies the thermometer mask: bits under the mask are inverted when the
// carry is set. Also forms the output mask, either the thermometer itself or
// a one-hot marker at the lowest zero.
// Assumes: therm_in is the lowest-zero thermometer of value_in.
module lzinc_apply #(
    parameter int W           = 8,
    parameter bit MASK_ONEHOT = 1'b0
) (
    input  logic [W-1:0] value_in,
    input  logic         carry_in,
    input  logic [W-1:0] therm_in,
    output logic [W-1:0] sum_out,
    output logic [W-1:0] mask_out
);
    // Masked complement gives value + carry without a carry chain.
    always_comb begin
        sum_out = value_in ^ (therm_in & {W{carry_in}});
    end

    generate
        if (MASK_ONEHOT) begin : g_onehot
            // Inside the thermometer, the only zero bit of the value is the lowest one.
            always_comb begin
                mask_out = therm_in & ~value_in;
            end
        end else begin : g_therm
            // Thermometer form goes out as is.
            always_comb begin
                mask_out = therm_in;
            end
        end
    endgenerate
endmodule

// File: rtl/lzinc_stage.sv
// Module lzinc_stage
// Top of the conditional incrementer. A recursive detector builds the
// lowest-zero thermometer, the apply stage forms the sum and mask, and one
// register stage holds the results.
// Assumes: WIDTH is a power of two from 2 to 32. Inputs are known at each
// rising edge after reset.
module lzinc_stage #(
    parameter int WIDTH       = 8,
    parameter bit MASK_ONEHOT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] x_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             all_ones_out,
    output logic [WIDTH-1:0] mask_out
);
    logic [WIDTH-1:0] therm;
    logic             all_ones;
    logic [WIDTH-1:0] sum_next;
    logic [WIDTH-1:0] mask_next;

    lzd_node #(.W(WIDTH)) u_detect (
        .bits_in      (x_in),
        .therm_out    (therm),
        .all_ones_out (all_ones)
    );

    lzinc_apply #(.W(WIDTH), .MASK_ONEHOT(MASK_ONEHOT)) u_apply (
        .value_in (x_in),
        .carry_in (carry_in),
        .therm_in (therm),
        .sum_out  (sum_next),
        .mask_out (mask_next)
    );

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_out      <= '0;
            all_ones_out <= 1'b0;
            mask_out     <= '0;
        end else begin
            sum_out      <= sum_next;
            all_ones_out <= all_ones;
            mask_out     <= mask_next;
        end
    end

    // R3: a clear carry passes the value through.
    assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_in |=> sum_out == $past(x_in));

    // R4: a set carry yields value plus one, wrapped.
    assert_increment_R4: assert property (@(posedge clk) disable iff (!rst_n)
        carry_in |=> sum_out == ($past(x_in) + 1'b1));

    // R5: all ones plus carry wraps to zero and raises the flag.
    assert_wrap_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_in && (&x_in)) |=> (sum_out == '0) && all_ones_out);

    // R6: the flag follows the all-ones state of the sampled value.
    assert_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> all_ones_out == (&$past(x_in)));

    generate
        if (MASK_ONEHOT) begin : g_chk_onehot
            // R8: at most one mask bit, and none exactly for an all-ones value.
            assert_onehot_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> $onehot0(mask_out) && ((mask_out == '0) == all_ones_out));
        end else begin : g_chk_therm
            // R7: the mask is a contiguous run of ones starting at bit 0.
            assert_therm_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> mask_out[0] && ((mask_out & (mask_out + 1'b1)) == '0));
        end
    endgenerate
endmodule

// File: tb/lzinc_stage_test.sv
`timescale 1ns/1ps
// Bench lzinc_stage_test
// Drives four widths from one shared stimulus and compares each output on
// every clock with a behavioural model built from integer arithmetic.
module lzinc_stage_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] stim_x = '0;
    logic        stim_c = 1'b0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    logic [7:0]  s8,  m8;   logic f8;
    logic [1:0]  s2,  m2;   logic f2;
    logic [15:0] s16, m16;  logic f16;
    logic [31:0] s32, m32;  logic f32;

    always #2 clk = ~clk;  // 250 MHz

    lzinc_stage #(.WIDTH(8), .MASK_ONEHOT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .x_in(stim_x[7:0]), .carry_in(stim_c),
        .sum_out(s8), .all_ones_out(f8), .mask_out(m8));
    lzinc_stage #(.WIDTH(2), .MASK_ONEHOT(1'b1)) uut_w2 (
        .clk(clk), .rst_n(rst_n), .x_in(stim_x[1:0]), .carry_in(stim_c),
        .sum_out(s2), .all_ones_out(f2), .mask_out(m2));
    lzinc_stage #(.WIDTH(16), .MASK_ONEHOT(1'b1)) uut_w16 (
        .clk(clk), .rst_n(rst_n), .x_in(stim_x[15:0]), .carry_in(stim_c),
        .sum_out(s16), .all_ones_out(f16), .mask_out(m16));
    lzinc_stage #(.WIDTH(32), .MASK_ONEHOT(1'b0)) uut_w32 (
        .clk(clk), .rst_n(rst_n), .x_in(stim_x), .carry_in(stim_c),
        .sum_out(s32), .all_ones_out(f32), .mask_out(m32));

    function automatic logic [31:0] wmask(int w);
        return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    endfunction

    function automatic logic [31:0] ref_sum(logic [31:0] x, logic c, int w);
        longint t = longint'(x & wmask(w)) + longint'(c);
        return 32'(t) & wmask(w);
    endfunction

    function automatic logic [31:0] ref_therm(logic [31:0] x, int w);
        logic [31:0] m = '0;
        for (int i = 0; i < w; i++) begin
            m[i] = 1'b1;
            if (!x[i]) break;
        end
        return m;
    endfunction

    function automatic logic [31:0] ref_onehot(logic [31:0] x, int w);
        for (int i = 0; i < w; i++)
            if (!x[i]) return 32'd1 << i;
        return '0;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare one instance's outputs with the model for (x, c).
    task automatic chk_inst(int w, bit onehot, logic [31:0] s, logic f, logic [31:0] m,
                            logic [31:0] x, logic c, string force_tag);
        logic [31:0] xm = x & wmask(w);
        bit          full = (xm == wmask(w));
        string       wt = (w == 8) ? "" : $sformatf(" R9 w%0d", w);
        string       st = (force_tag != "") ? force_tag : (!c ? "R3" : (full ? "R5" : "R4"));
        string       ft = (force_tag != "") ? force_tag : (full && c ? "R5" : "R6");
        string       mt = (force_tag != "") ? force_tag : (onehot ? "R8" : "R7");
        chk({st, wt}, "sum", s, ref_sum(x, c, w));
        chk({ft, wt}, "all_ones", {31'd0, f}, {31'd0, full});
        chk({mt, wt}, "mask", m, onehot ? ref_onehot(x, w) : ref_therm(x, w));
    endtask

    task automatic verify_all(logic [31:0] x, logic c, string force_tag);
        chk_inst(8,  1'b0, {24'd0, s8},  f8,  {24'd0, m8},  x, c, force_tag);
        chk_inst(2,  1'b1, {30'd0, s2},  f2,  {30'd0, m2},  x, c, force_tag);
        chk_inst(16, 1'b1, {16'd0, s16}, f16, {16'd0, m16}, x, c, force_tag);
        chk_inst(32, 1'b0, s32,          f32, m32,          x, c, force_tag);
    endtask

    task automatic chk_reset();
        chk("R1", "sum w8",  {24'd0, s8},  '0);
        chk("R1", "mask w8", {24'd0, m8},  '0);
        chk("R1", "flag w8", {31'd0, f8},  '0);
        chk("R1", "sum w32", s32, '0);
        chk("R1", "mask w32", m32, '0);
        chk("R1", "flag w2", {31'd0, f2}, '0);
        chk("R1", "mask w16", {16'd0, m16}, '0);
    endtask

    logic [31:0] px;
    logic        pc;
    bit          have_prev = 1'b0;

    // Drive at the falling edge, confirm the old outputs hold (R2),
    // then check the new outputs just after the rising edge.
    task automatic apply(logic [31:0] x, logic c);
        @(negedge clk);
        stim_x = x;
        stim_c = c;
        #1;
        if (have_prev) verify_all(px, pc, "R2");
        @(posedge clk);
        #1;
        verify_all(x, c, "");
        px = x;
        pc = c;
        have_prev = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        stim_x = 32'hFFFF_FFFF;
        stim_c = 1'b1;
        @(posedge clk);
        #1;
        chk_reset();
        @(negedge clk);
        rst_n = 1'b1;
        have_prev = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        stim_x = 32'hA5A5_5A5A;
        stim_c = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk_reset();  // R1 from power-up
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive 2-bit and 8-bit values with both carries; random upper bits.
        for (int v = 0; v < 512; v++)
            apply({$urandom() & 32'hFFFF_FF00} | 32'(v[7:0]), v[8]);

        // Corner values: all ones, all zeros, top-bit zero, long low runs.
        apply(32'hFFFF_FFFF, 1'b1);  // R5 wrap at every width
        apply(32'hFFFF_FFFF, 1'b0);
        apply(32'h0000_0000, 1'b1);
        apply(32'h7FFF_FFFF, 1'b1);  // lowest zero at bit 31
        apply(32'hFFFF_7FFF, 1'b1);  // lowest zero at bit 15
        apply(32'h0000_FFFF, 1'b0);
        apply(32'hFFFF_0000, 1'b1);

        // Reset in the middle of traffic.
        do_reset();

        // Random values, half of them with a forced run of low ones.
        for (int n = 0; n < 2000; n++) begin
            logic [31:0] r = $urandom();
            if ($urandom() % 2) r = r | ((32'd1 << ($urandom() % 32)) - 32'd1);
            apply(r, 1'($urandom() % 2));
        end

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule